// File: doc/BRIEF.md
# Paged Memory Mapping Unit

This block sits between the 16-bit address bus of an 8-bit processor and a larger physical memory. The logical space is cut into pages of 4 KB. The top four address bits pick one of sixteen mapping registers. Each register holds an 8-bit physical page number. The unit places that page number above the unchanged 12-bit offset, which gives a 20-bit physical address and reaches 1 MB. Translation is combinational within the bus cycle.

Every page also carries a write-protect bit. A processor write that lands in a protected page is kept away from memory. The unit flags the write as blocked, latches the event together with the offending page number, and can raise an interrupt that software acknowledges. Software programs the unit through a small register window on the same processor bus. Accesses to that window are never translated and never protected. Mapping starts disabled, so out of reset the machine sees an identity map.

Register window layout, as offsets from the window base: offsets 0 to 15 hold the page registers for logical pages 0 to 15. Offset 16 holds the protect bits for pages 0 to 7, with bit k for page k. Offset 17 holds the protect bits for pages 8 to 15, with bit k for page 8+k. Offset 18 is the control register. Offset 19 is the status register.

Top module: `page_mapper`

## Requirements
- R1: For every access, physical address bits 11:0 equal CPU address bits 11:0.
- R2: When control bit 0 is 1 and the access lies outside the window, physical bits 19:12 equal the page register selected by CPU address bits 15:12.
- R3: When control bit 0 is 0 and the access lies outside the window, physical bits 19:12 are zero-extended CPU address bits 15:12. Window accesses always present the zero-extended CPU address.
- R4: A CPU write to window offset n (0 to 15) loads page register n from the write data. The new value is used for translation and readback from the next cycle on.
- R5: The protect registers work as follows. Offset 16 bit k protects page k, and offset 17 bit k protects page 8+k. A write outside the window to a protected page drives mem_we low and wr_blocked high. A read from a protected page is translated normally and is not flagged.
- R6: A valid write outside the window to an unprotected page drives mem_we high. mem_we is low for reads and for idle cycles.
- R7: The window is the 32 addresses starting at 0xDE00. An access there drives win_sel high, mem_we low and wr_blocked low, even when its page is protected.
- R8: A blocked write sets status bit 0 in the next cycle and stores its logical page in status bits 4:1. Without a blocked write or a clear, the latch holds its value.
- R9: irq is the status latch ANDed with control bit 1. Writing status with data bit 0 set clears the latch, and writing it with data bit 0 clear leaves the latch as it is.
- R10: After reset, control, protect bits, the status latch and irq read as zero.
- R11: During a window read, reg_rdata gives the addressed register in the same cycle. Control reads back in bits 1:0. Status reads back as {3'b0, page, latch}. Unused offsets 20 to 31 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Bus cycle active |
| cpu_we | input | 1 | Bus cycle is a write |
| cpu_addr | input | 16 | Logical CPU address |
| cpu_wdata | input | 8 | CPU write data |
| phys_addr | output | 20 | Translated physical address |
| mem_we | output | 1 | Write enable to memory |
| wr_blocked | output | 1 | Current write hits a protected page |
| win_sel | output | 1 | Access targets the register window |
| reg_rdata | output | 8 | Register readback data |
| irq | output | 1 | Protected-write interrupt request |

## Verification
The bench uses the default parameters: a 16-bit logical address, 4 KB pages, 8-bit page numbers, and a window at 0xDE00 that is 32 bytes wide. With these values the window sits inside page 13, so protecting that page shows directly that window writes bypass protection. The page count is small enough that random traffic reaches every page register and every protect bit many times. The five window address bits also let random accesses reach the unused offsets, which must read zero.

// File: rtl/mmu_pkg.sv
`timescale 1ns/1ps
package mmu_pkg;
  // control register fields, bit 1 = interrupt enable, bit 0 = mapping enable
  typedef struct packed {
    logic irq_en;
    logic map_en;
  } ctrl_t;
endpackage

// File: rtl/mmu_xlate.sv
`timescale 1ns/1ps
module mmu_xlate #(
  parameter int LA_W      = 16,
  parameter int OFF_W     = 12,
  parameter int PPN_W     = 8,
  parameter int WIN_AW    = 5,
  parameter int WIN_BASE  = 16'hDE00,
  localparam int PAGE_BITS = LA_W - OFF_W,
  localparam int PAGES     = 1 << PAGE_BITS,
  localparam int PA_W      = PPN_W + OFF_W
) (
  input  logic                 cpu_valid,
  input  logic                 cpu_we,
  input  logic [LA_W-1:0]      cpu_addr,
  input  logic                 map_en,
  input  logic [PPN_W-1:0]     look_ppn,
  input  logic [PAGES-1:0]     prot_vec,
  output logic [PAGE_BITS-1:0] page,
  output logic [WIN_AW-1:0]    win_off,
  output logic                 win_hit,
  output logic [PA_W-1:0]      phys_addr,
  output logic                 mem_we,
  output logic                 blocked
);
  localparam logic [LA_W-1:0] WIN_B = LA_W'(WIN_BASE);

  logic [PPN_W-1:0] ppn;
  logic             wr_cyc;

  assign page    = cpu_addr[LA_W-1 -: PAGE_BITS];
  assign win_off = cpu_addr[WIN_AW-1:0];
  assign win_hit = cpu_addr[LA_W-1:WIN_AW] == WIN_B[LA_W-1:WIN_AW];
  assign wr_cyc  = cpu_valid && cpu_we;

  always_comb begin
    if (map_en && !win_hit) ppn = look_ppn;
    else                    ppn = {{(PPN_W-PAGE_BITS){1'b0}}, page};
  end

  assign phys_addr = {ppn, cpu_addr[OFF_W-1:0]};
  assign blocked   = wr_cyc && !win_hit && prot_vec[page];
  assign mem_we    = wr_cyc && !win_hit && !prot_vec[page];
endmodule

// File: rtl/mmu_regfile.sv
`timescale 1ns/1ps
module mmu_regfile
  import mmu_pkg::*;
#(
  parameter int PAGE_BITS = 4,
  parameter int PPN_W     = 8,
  parameter int DW        = 8,
  parameter int WIN_AW    = 5,
  localparam int PAGES      = 1 << PAGE_BITS,
  localparam int PROT_BYTES = PAGES / 8,
  localparam int PROT_OFF   = PAGES,
  localparam int CTRL_OFF   = PAGES + PROT_BYTES,
  localparam int STAT_OFF   = CTRL_OFF + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [WIN_AW-1:0]    wr_off,
  input  logic [DW-1:0]        wr_data,
  input  logic [WIN_AW-1:0]    rd_off,
  output logic [DW-1:0]        rd_data,
  input  logic [PAGE_BITS-1:0] look_page,
  output logic [PPN_W-1:0]     look_ppn,
  output logic [PAGES-1:0]     prot_vec,
  output ctrl_t                ctrl,
  input  logic                 blk_evt,
  input  logic [PAGE_BITS-1:0] blk_page,
  output logic                 irq
);
  logic [PPN_W-1:0]     page_mem [PAGES];
  logic [PAGES-1:0]     prot_q;
  ctrl_t                ctrl_q;
  logic                 latch_q;
  logic [PAGE_BITS-1:0] last_q;
  logic                 pg_we, ctrl_we, stat_we, ack;

  assign pg_we   = wr_en && (int'(wr_off) < PAGES);
  assign ctrl_we = wr_en && (int'(wr_off) == CTRL_OFF);
  assign stat_we = wr_en && (int'(wr_off) == STAT_OFF);
  assign ack     = stat_we && wr_data[0];

  // page table kept free of reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (pg_we) page_mem[wr_off[PAGE_BITS-1:0]] <= wr_data[PPN_W-1:0];
  end
  assign look_ppn = page_mem[look_page];

  for (genvar b = 0; b < PROT_BYTES; b++) begin : g_prot
    always_ff @(posedge clk) begin
      if (rst) prot_q[b*8 +: 8] <= '0;
      else if (wr_en && int'(wr_off) == PROT_OFF + b) prot_q[b*8 +: 8] <= wr_data[7:0];
    end
  end
  assign prot_vec = prot_q;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wr_data[1:0]);
  end
  assign ctrl = ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      last_q  <= '0;
    end else if (blk_evt) begin
      latch_q <= 1'b1;
      last_q  <= blk_page;
    end else if (ack) begin
      latch_q <= 1'b0;
    end
  end

  assign irq = latch_q && ctrl_q.irq_en;

  always_comb begin
    rd_data = '0;
    if (int'(rd_off) < PAGES) rd_data = DW'(page_mem[rd_off[PAGE_BITS-1:0]]);
    for (int b = 0; b < PROT_BYTES; b++)
      if (int'(rd_off) == PROT_OFF + b) rd_data = DW'(prot_q[b*8 +: 8]);
    if (int'(rd_off) == CTRL_OFF) rd_data = DW'(ctrl_q);
    if (int'(rd_off) == STAT_OFF) begin
      rd_data[0]           = latch_q;
      rd_data[PAGE_BITS:1] = last_q;
    end
  end

  // R4
  pg_wr_chk: assert property (@(posedge clk) disable iff (rst)
    pg_we |=> page_mem[$past(wr_off[PAGE_BITS-1:0])] == $past(wr_data[PPN_W-1:0]));
  // R8
  blk_latch_chk: assert property (@(posedge clk) disable iff (rst)
    blk_evt |=> latch_q && last_q == $past(blk_page));
  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !blk_evt && !ack |=> $stable(latch_q));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    blk_evt && ctrl_q.irq_en && !wr_en |=> irq);
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack && !blk_evt |=> !latch_q && !irq);
  // R10
  rst_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ctrl_q == '0 && prot_q == '0 && !latch_q);
endmodule

// File: rtl/page_mapper.sv
`timescale 1ns/1ps
module page_mapper
  import mmu_pkg::*;
#(
  parameter int LA_W     = 16,
  parameter int OFF_W    = 12,
  parameter int PPN_W    = 8,
  parameter int DW       = 8,
  parameter int WIN_AW   = 5,
  parameter int WIN_BASE = 16'hDE00,
  localparam int PAGE_BITS = LA_W - OFF_W,
  localparam int PAGES     = 1 << PAGE_BITS,
  localparam int PA_W      = PPN_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_valid,
  input  logic            cpu_we,
  input  logic [LA_W-1:0] cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [PA_W-1:0] phys_addr,
  output logic            mem_we,
  output logic            wr_blocked,
  output logic            win_sel,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);
  logic [PAGE_BITS-1:0] page;
  logic [WIN_AW-1:0]    win_off;
  logic                 win_hit;
  logic [PPN_W-1:0]     look_ppn;
  logic [PAGES-1:0]     prot_vec;
  ctrl_t                ctrl;

  mmu_xlate #(
    .LA_W(LA_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
    .WIN_AW(WIN_AW), .WIN_BASE(WIN_BASE)
  ) xlate_i (
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .map_en(ctrl.map_en), .look_ppn(look_ppn), .prot_vec(prot_vec),
    .page(page), .win_off(win_off), .win_hit(win_hit),
    .phys_addr(phys_addr), .mem_we(mem_we), .blocked(wr_blocked)
  );

  mmu_regfile #(
    .PAGE_BITS(PAGE_BITS), .PPN_W(PPN_W), .DW(DW), .WIN_AW(WIN_AW)
  ) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(cpu_valid && cpu_we && win_hit), .wr_off(win_off), .wr_data(cpu_wdata),
    .rd_off(win_off), .rd_data(reg_rdata),
    .look_page(page), .look_ppn(look_ppn), .prot_vec(prot_vec),
    .ctrl(ctrl), .blk_evt(wr_blocked), .blk_page(page), .irq(irq)
  );

  assign win_sel = cpu_valid && win_hit;

  // R5
  prot_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !prot_vec[cpu_addr[LA_W-1 -: PAGE_BITS]]);
  // R7
  win_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    win_sel |-> !mem_we && !wr_blocked);
endmodule

// File: tb/page_mapper_tb.sv
`timescale 1ns/1ps
module page_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [19:0] phys_addr;
  logic        mem_we, wr_blocked, win_sel, irq;
  logic [7:0]  reg_rdata;

  int checks = 0, fails = 0;

  // bench model of the programmed state
  logic [7:0]  m_page [16];
  logic [15:0] m_prot = '0;
  logic [1:0]  m_ctrl = '0;
  logic        m_latch = 1'b0;
  logic [3:0]  m_last = '0;

  always #2.5 clk = ~clk;

  page_mapper dut_i (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .phys_addr(phys_addr),
    .mem_we(mem_we), .wr_blocked(wr_blocked), .win_sel(win_sel),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic in_win(logic [15:0] a);
    return a[15:5] == 11'(16'hDE00 >> 5);
  endfunction

  function automatic logic [19:0] exp_phys(logic [15:0] a);
    if (in_win(a) || !m_ctrl[0]) return {4'h0, a};
    return {m_page[a[15:12]], a[11:0]};
  endfunction

  function automatic logic [7:0] exp_rd(logic [4:0] o);
    if (o < 5'd16) return m_page[o[3:0]];
    case (o)
      5'd16: return m_prot[7:0];
      5'd17: return m_prot[15:8];
      5'd18: return {6'h0, m_ctrl};
      5'd19: return {3'h0, m_last, m_latch};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic v, logic w, logic [15:0] a, logic [7:0] d);
    logic win, prot, blk;
    @(negedge clk);
    cpu_valid = v; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    #1;
    win  = in_win(a);
    prot = m_prot[a[15:12]];
    blk  = v && w && !win && prot;
    if (win)            chk("R3/R7 window phys", phys_addr, exp_phys(a));
    else if (m_ctrl[0]) chk("R1/R2 mapped phys", phys_addr, exp_phys(a));
    else                chk("R1/R3 identity phys", phys_addr, exp_phys(a));
    if (win) chk("R7 win_sel", {win_sel, mem_we, wr_blocked}, {v, 2'b00});
    else if (prot) chk("R5 protected page", {mem_we, wr_blocked}, {1'b0, blk});
    else chk("R6 mem_we", {mem_we, wr_blocked}, {v && w, 1'b0});
    if (v && !w && win) chk("R11 readback", reg_rdata, exp_rd(a[4:0]));
    chk("R9 irq level", irq, m_latch && m_ctrl[1]);
    @(posedge clk);
    if (v && w && win) begin
      if (a[4:0] < 5'd16) m_page[a[3:0]] = d;
      else if (a[4:0] == 5'd16) m_prot[7:0] = d;
      else if (a[4:0] == 5'd17) m_prot[15:8] = d;
      else if (a[4:0] == 5'd18) m_ctrl = d[1:0];
      else if (a[4:0] == 5'd19 && d[0]) m_latch = 1'b0;
    end else if (blk) begin
      m_latch = 1'b1;
      m_last  = a[15:12];
    end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10: control, protect and status read zero after reset
    step(1, 0, 16'hDE12, 0);
    step(1, 0, 16'hDE13, 0);
    step(1, 0, 16'hDE10, 0);
    step(1, 0, 16'hDE11, 0);
    // R3 R6: identity map and plain write while mapping is off
    step(1, 1, 16'h3ABC, 8'h55);
    step(0, 0, 16'h4000, 0);
    // R4: load every page register and read them back
    for (int i = 0; i < 16; i++) step(1, 1, 16'hDE00 + 16'(i), 8'((i * 17 + 5) & 8'hFF));
    for (int i = 0; i < 16; i++) step(1, 0, 16'hDE00 + 16'(i), 0);
    // R2: mapping on
    step(1, 1, 16'hDE12, 8'h01);
    step(1, 0, 16'h5123, 0);
    step(1, 1, 16'hF000, 8'h11);
    // R5: protect page 5, write blocked, read normal
    step(1, 1, 16'hDE10, 8'h20);
    step(1, 1, 16'h5FFF, 8'hAA);
    step(1, 0, 16'h5000, 0);
    // R8: status shows latch and page 5, R9 irq still low
    step(1, 0, 16'hDE13, 0);
    // R9: enable irq, then zero-write keeps, one-write clears
    step(1, 1, 16'hDE12, 8'h03);
    step(1, 0, 16'h0000, 0);
    step(1, 1, 16'hDE13, 8'hFE);
    step(1, 0, 16'hDE13, 0);
    step(1, 1, 16'hDE13, 8'h01);
    step(1, 0, 16'hDE13, 0);
    // R7: protect page 13, window write passes, other page-13 write blocked
    step(1, 1, 16'hDE11, 8'h20);
    step(1, 1, 16'hDE05, 8'h77);
    step(1, 1, 16'hD000, 8'h01);
    step(1, 0, 16'hDE13, 0);
    // R11: unused offset reads zero, and writing it has no effect
    step(1, 1, 16'hDE1F, 8'hFF);
    step(1, 0, 16'hDE1F, 0);
    step(1, 0, 16'hDE14, 0);
    // mixed random traffic, a quarter of it aimed at the window
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'($urandom);
      d = 8'($urandom);
      if ($urandom % 4 == 0) a = 16'hDE00 | 16'($urandom % 32);
      if (a == 16'hDE12 && ($urandom % 2 == 0)) d[0] = 1'b1;
      step(1'($urandom % 8 != 0), 1'($urandom % 2), a, d);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule